// File: doc/BRIEF.md
# Time Base and Interval Decrementer

This block keeps a free-running 64-bit time base and a 32-bit interval decrementer that share one tick. The tick comes either from the core clock, one per cycle, or from rising edges of an external timer clock. A select input chooses the source, and the external clock is synchronized first. Software uses a small word-wide register port to read and write both halves of the time base, load the decrementer, and program a control word. That control word holds an interrupt enable and an auto-reload option.

When a tick arrives while the decrementer holds 1, the block sets a sticky status bit. The count then either stops at zero or, with auto-reload on, goes back to the last value software loaded. The interrupt output is the status bit gated by the enable. Software clears the status bit by writing a one to it. When the time base wraps from all ones to zero, nothing is flagged.

Top module: `tbd_timer_top`

## Requirements
- R1: After reset the time base, the decrementer count, its reload value, the control word and the status bit all read zero, and `irq` is low.
- R2: With `tick_sel`=0, the time base advances by one on every clock edge that has no time-base write.
- R3: With `tick_sel`=1, each rising edge of `ext_tclk` advances the time base by exactly one. The increment lands on the third clock edge after the edge is first sampled. A level held high, or a falling edge, adds nothing.
- R4: Address 0 is the low word and address 1 the high word of the time base. Both read back on `reg_rdata`. A write to either word loads that word, and in that cycle the other word holds and no increment occurs.
- R5: When the time base steps from all ones to zero, it wraps, and neither the status bit nor `irq` changes.
- R6: A write to address 2 loads both the decrementer count and its reload value. Reading address 2 returns the current count. Each tick lowers a non-zero count by one.
- R7: A tick while the count is 1 sets the status bit. Without auto-reload, the count becomes 0 and stays there.
- R8: With auto-reload on (control bit 1 at address 3), a tick while the count is 1 loads the count from the reload value, and counting continues.
- R9: A count of 0 does not change on ticks and never sets the status bit.
- R10: A decrementer write in the same cycle as a tick takes effect, and that tick does not decrement.
- R11: The status bit is bit 0 at address 4. Writing 1 there clears it, and writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R12: `irq` is high exactly when the status bit is set and the interrupt enable (control bit 0 at address 3) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tclk | input | 1 | External timer clock, asynchronous |
| tick_sel | input | 1 | Tick source: 0 core clock, 1 external clock edges |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interval interrupt |

## Verification
The assertions assume that `tick_sel` changes only while no external pulse is in flight. They also assume that the register port carries one write per cycle, to a valid address. The bench changes the source only between scenarios, after waiting for the synchronizer to drain. It drives every write and every external-clock transition on the falling clock edge. Cases that depend on exact timing, such as a write colliding with a tick or a set colliding with a clear, run on the core-clock tick, where the tick in every cycle is known.

// File: rtl/tbd_pkg.sv
`timescale 1ns/1ps
package tbd_pkg;
   typedef struct packed {
      logic auto_rl;
      logic irq_en;
   } tbd_ctrl_t;

   function automatic int unsigned tbd_clog2(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/tbd_tick_gen.sv
`timescale 1ns/1ps
module tbd_tick_gen #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_clk,
   input  logic sel_ext,
   output logic tick
);
   localparam int MSB = SYNC_STAGES - 1;

   logic [MSB:0] sync_q;
   logic         edge_q;
   logic         ext_rise;

   generate
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= ext_clk;
         end
      end else begin : g_many
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[MSB-1:0], ext_clk};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) edge_q <= 1'b0;
      else        edge_q <= sync_q[MSB];
   end

   assign ext_rise = sync_q[MSB] & ~edge_q;
   assign tick     = sel_ext ? ext_rise : 1'b1;
endmodule

// File: rtl/tbd_time_base.sv
`timescale 1ns/1ps
module tbd_time_base #(
   parameter int TB_W   = 64,
   parameter int WORD_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic [TB_W/WORD_W-1:0]  wr_word,
   input  logic [WORD_W-1:0]       wdata,
   output logic [TB_W-1:0]         tb
);
   localparam int N_WORDS = TB_W / WORD_W;

   logic [WORD_W-1:0] word_q [N_WORDS];
   logic [TB_W-1:0]   tb_inc;
   logic              any_wr;

   assign any_wr = |wr_word;
   assign tb_inc = tb + TB_W'(1);

   generate
      for (genvar i = 0; i < N_WORDS; i++) begin : g_word
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               word_q[i] <= '0;
            end else if (any_wr) begin
               if (wr_word[i]) word_q[i] <= wdata;
            end else if (tick) begin
               word_q[i] <= tb_inc[i*WORD_W +: WORD_W];
            end
         end
         assign tb[i*WORD_W +: WORD_W] = word_q[i];
      end
   endgenerate
endmodule

// File: rtl/tbd_decrementer.sv
`timescale 1ns/1ps
module tbd_decrementer #(
   parameter int DEC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [DEC_W-1:0] load_val,
   input  logic             auto_rl,
   output logic [DEC_W-1:0] count,
   output logic [DEC_W-1:0] reload,
   output logic             expire
);
   logic at_one;

   assign at_one = (count == DEC_W'(1));
   assign expire = tick & ~load & at_one;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count  <= '0;
         reload <= '0;
      end else if (load) begin
         count  <= load_val;
         reload <= load_val;
      end else if (tick && count != '0) begin
         if (at_one) count <= auto_rl ? reload : '0;
         else        count <= count - DEC_W'(1);
      end
   end
endmodule

// File: rtl/tbd_ctrl_status.sv
`timescale 1ns/1ps
module tbd_ctrl_status
   import tbd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ctrl_wr,
   input  tbd_ctrl_t ctrl_wdata,
   input  logic      stat_clr,
   input  logic      expire,
   output tbd_ctrl_t ctrl,
   output logic      status,
   output logic      irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl <= '0;
      else if (ctrl_wr) ctrl <= ctrl_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        status <= 1'b0;
      else if (expire)   status <= 1'b1;
      else if (stat_clr) status <= 1'b0;
   end

   assign irq = status & ctrl.irq_en;
endmodule

// File: rtl/tbd_timer_top.sv
`timescale 1ns/1ps
module tbd_timer_top
   import tbd_pkg::*;
#(
   parameter int TB_W        = 64,
   parameter int DATA_W      = 32,
   parameter int DEC_W       = 32,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_tclk,
   input  logic              tick_sel,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int TB_WORDS = TB_W / DATA_W;
   localparam int A_DEC    = TB_WORDS;
   localparam int A_CTRL   = TB_WORDS + 1;
   localparam int A_STAT   = TB_WORDS + 2;
   localparam int N_REGS   = TB_WORDS + 3;

   generate
      if (TB_W % DATA_W != 0) begin : g_bad_tb
         $error("TB_W must be a multiple of DATA_W");
      end
      if (DEC_W > DATA_W || DEC_W < 2) begin : g_bad_dec
         $error("DEC_W must be in 2..DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must hold the control bits");
      end
      if (tbd_clog2(N_REGS) > ADDR_W) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic                tick;
   logic [TB_WORDS-1:0] tb_wr;
   logic                tb_wr_any;
   logic [TB_W-1:0]     tb;
   logic                dec_load;
   logic [DEC_W-1:0]    dec_cnt;
   logic [DEC_W-1:0]    dec_rl;
   logic                expire;
   logic                ctrl_wr;
   logic                stat_clr;
   tbd_ctrl_t           ctrl;
   tbd_ctrl_t           ctrl_wdata;
   logic                status;

   generate
      for (genvar i = 0; i < TB_WORDS; i++) begin : g_tbsel
         assign tb_wr[i] = reg_wr && (reg_addr == ADDR_W'(i));
      end
   endgenerate

   assign tb_wr_any  = |tb_wr;
   assign dec_load   = reg_wr && (reg_addr == ADDR_W'(A_DEC));
   assign ctrl_wr    = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
   assign stat_clr   = reg_wr && (reg_addr == ADDR_W'(A_STAT)) && reg_wdata[0];
   assign ctrl_wdata = '{auto_rl: reg_wdata[1], irq_en: reg_wdata[0]};

   tbd_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .ext_clk (ext_tclk),
      .sel_ext (tick_sel),
      .tick    (tick)
   );

   tbd_time_base #(.TB_W(TB_W), .WORD_W(DATA_W)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wr_word (tb_wr),
      .wdata   (reg_wdata),
      .tb      (tb)
   );

   tbd_decrementer #(.DEC_W(DEC_W)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (dec_load),
      .load_val (reg_wdata[DEC_W-1:0]),
      .auto_rl  (ctrl.auto_rl),
      .count    (dec_cnt),
      .reload   (dec_rl),
      .expire   (expire)
   );

   tbd_ctrl_status u_cs (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_wr    (ctrl_wr),
      .ctrl_wdata (ctrl_wdata),
      .stat_clr   (stat_clr),
      .expire     (expire),
      .ctrl       (ctrl),
      .status     (status),
      .irq        (irq)
   );

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < TB_WORDS; i++) begin
         if (reg_addr == ADDR_W'(i)) reg_rdata = tb[i*DATA_W +: DATA_W];
      end
      if (reg_addr == ADDR_W'(A_DEC))  reg_rdata = DATA_W'(dec_cnt);
      if (reg_addr == ADDR_W'(A_CTRL)) reg_rdata = DATA_W'({ctrl.auto_rl, ctrl.irq_en});
      if (reg_addr == ADDR_W'(A_STAT)) reg_rdata = DATA_W'(status);
   end
endmodule

// File: rtl/tbd_timer_chk.sv
`timescale 1ns/1ps
module tbd_timer_chk #(
   parameter int TB_W  = 64,
   parameter int DEC_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             tick_sel,
   input logic             tb_wr_any,
   input logic [TB_W-1:0]  tb,
   input logic             dec_load,
   input logic [DEC_W-1:0] dec_cnt,
   input logic [DEC_W-1:0] dec_rl,
   input logic             auto_rl,
   input logic             status,
   input logic             irq_en,
   input logic             irq
);
   // R2: tick without a write advances the time base by one
   a_r2_tb_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !tb_wr_any) |=> (tb == $past(tb) + TB_W'(1)));

   // R3: no tick and no write leaves the time base alone
   a_r3_tb_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !tb_wr_any) |=> $stable(tb));

   // R3: external ticks are single-cycle pulses
   a_r3_ext_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_sel && tick) |=> !(tick_sel && tick));

   // R5: wrap of the time base raises no status
   a_r5_wrap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (&tb) && !tb_wr_any && !status && dec_cnt != DEC_W'(1)) |=> !status);

   // R7: count stops at zero without auto-reload
   a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !dec_load && dec_cnt == DEC_W'(1) && !auto_rl) |=> (dec_cnt == '0 && status));

   // R7: status only rises on an expiry
   a_r7_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status) |-> $past(tick && !dec_load && dec_cnt == DEC_W'(1)));

   // R8: auto-reload restores the last loaded value
   a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !dec_load && dec_cnt == DEC_W'(1) && auto_rl) |=> (dec_cnt == $past(dec_rl)));

   // R9: a zero count stays idle
   a_r9_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_cnt == '0 && !dec_load) |=> (dec_cnt == '0));

   // R10: load wins over a concurrent tick
   a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      dec_load |=> (dec_cnt == dec_rl));

   // R12: no interrupt while disabled
   a_r12_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);
endmodule

bind tbd_timer_top tbd_timer_chk #(.TB_W(TB_W), .DEC_W(DEC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .tick_sel  (tick_sel),
   .tb_wr_any (tb_wr_any),
   .tb        (tb),
   .dec_load  (dec_load),
   .dec_cnt   (dec_cnt),
   .dec_rl    (dec_rl),
   .auto_rl   (ctrl.auto_rl),
   .status    (status),
   .irq_en    (ctrl.irq_en),
   .irq       (irq)
);

// File: tb/tbd_timer_top_tb.sv
`timescale 1ns/1ps
module tbd_timer_top_tb;
   localparam logic [2:0] A_LO = 3'd0, A_HI = 3'd1, A_DEC = 3'd2, A_CTRL = 3'd3, A_STAT = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_tclk = 1'b0;
   logic        tick_sel = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   tbd_timer_top u_dut (
      .clk(clk), .rst_n(rst_n), .ext_tclk(ext_tclk), .tick_sel(tick_sel),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   // called at a falling edge; ends at the next falling edge
   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic ext_pulse();
      ext_tclk = 1'b1;
      repeat (4) @(negedge clk);
      ext_tclk = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_LO, v);   check("R1 tb_lo", v, 0);
      rd(A_HI, v);   check("R1 tb_hi", v, 0);
      rd(A_DEC, v);  check("R1 count", v, 0);
      rd(A_CTRL, v); check("R1 ctrl", v, 0);
      rd(A_STAT, v); check("R1 status", v, 0);
      check("R1 irq", {31'd0, irq}, 0);
   endtask

   task automatic t_core_count();
      logic [31:0] a, b;
      tick_sel = 1'b0;
      @(negedge clk);
      rd(A_LO, a);
      repeat (7) @(negedge clk);
      rd(A_LO, b);
      check("R2 core advance", b - a, 7);
   endtask

   task automatic t_tb_write();
      logic [31:0] v;
      wr(A_LO, 32'hFFFF_FFF0);
      wr(A_HI, 32'h0000_0012);
      rd(A_LO, v); check("R4 lo held", v, 32'hFFFF_FFF0);
      rd(A_HI, v); check("R4 hi loaded", v, 32'h0000_0012);
      @(negedge clk);
      rd(A_LO, v); check("R4 lo resumes", v, 32'hFFFF_FFF1);
   endtask

   task automatic t_wrap();
      logic [31:0] v;
      wr(A_HI, 32'hFFFF_FFFF);
      wr(A_LO, 32'hFFFF_FFFE);
      repeat (2) @(negedge clk);
      rd(A_HI, v); check("R5 wrap hi", v, 0);
      rd(A_LO, v); check("R5 wrap lo", v, 0);
      rd(A_STAT, v); check("R5 no status", v, 0);
   endtask

   task automatic t_ext_tb();
      logic [31:0] a, b;
      tick_sel = 1'b1;
      repeat (4) @(negedge clk);
      rd(A_LO, a);
      ext_pulse();
      ext_pulse();
      rd(A_LO, b); check("R3 two edges", b - a, 2);
      ext_tclk = 1'b1;
      repeat (12) @(negedge clk);
      rd(A_LO, b); check("R3 level adds one", b - a, 3);
      ext_tclk = 1'b0;
      repeat (6) @(negedge clk);
      rd(A_LO, b); check("R3 falling adds none", b - a, 3);
   endtask

   task automatic t_dec_stop();
      logic [31:0] v;
      wr(A_CTRL, 32'h1);
      wr(A_DEC, 32'd3);
      ext_pulse(); rd(A_DEC, v); check("R6 dec 3->2", v, 2);
      ext_pulse(); rd(A_DEC, v); check("R6 dec 2->1", v, 1);
      rd(A_STAT, v); check("R7 not yet", v, 0);
      ext_pulse(); rd(A_DEC, v); check("R7 stops at 0", v, 0);
      rd(A_STAT, v); check("R7 status set", v, 1);
      check("R12 irq on", {31'd0, irq}, 1);
      wr(A_CTRL, 32'h0);
      check("R12 irq gated", {31'd0, irq}, 0);
      wr(A_CTRL, 32'h1);
      wr(A_STAT, 32'h0);
      rd(A_STAT, v); check("R11 write 0 keeps", v, 1);
      wr(A_STAT, 32'h1);
      rd(A_STAT, v); check("R11 write 1 clears", v, 0);
      check("R12 irq off", {31'd0, irq}, 0);
      ext_pulse(); ext_pulse();
      rd(A_DEC, v);  check("R9 zero idle", v, 0);
      rd(A_STAT, v); check("R9 no status", v, 0);
   endtask

   task automatic t_reload();
      logic [31:0] v;
      wr(A_CTRL, 32'h3);
      rd(A_CTRL, v); check("R8 ctrl read", v, 3);
      wr(A_DEC, 32'd2);
      ext_pulse(); rd(A_DEC, v); check("R8 2->1", v, 1);
      ext_pulse(); rd(A_DEC, v); check("R8 reloaded", v, 2);
      rd(A_STAT, v); check("R8 status", v, 1);
      ext_pulse(); rd(A_DEC, v); check("R8 continues", v, 1);
      wr(A_CTRL, 32'h1);
      wr(A_STAT, 32'h1);
   endtask

   task automatic t_collide();
      logic [31:0] v;
      tick_sel = 1'b0;
      repeat (2) @(negedge clk);
      wr(A_DEC, 32'd5);
      rd(A_DEC, v); check("R10 write beats tick", v, 5);
      @(negedge clk);
      rd(A_DEC, v); check("R10 then decrements", v, 4);
      wr(A_DEC, 32'd2);
      @(negedge clk);
      wr(A_STAT, 32'h1);
      rd(A_STAT, v); check("R11 set beats clear", v, 1);
      rd(A_DEC, v);  check("R7 core stop", v, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick_sel = 1'b1;
      t_reset();
      t_core_count();
      t_tb_write();
      t_wrap();
      t_ext_tb();
      t_dec_stop();
      t_reload();
      t_collide();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule